// File: doc/BRIEF.md
# Inclusive Second-Level Coherence Bridge

This block sits between a lower shared bus, on which several private first-level caches talk, and an upper shared bus that links many such clusters. It keeps a direct-mapped tag and state array that always covers every address cached below it. Lower-bus requests that hit here are finished locally. Requests that miss are passed to the upper bus. An initial write-through from below is also passed up, and it leaves the line owned exclusively at this level.

Coherency events seen on the upper bus are turned into traffic on the lower bus, and only for lines this block holds. A remote write to a held line becomes a downward invalidate, which the lower caches see as an ordinary bus write. A remote read of a line that may be modified below becomes a downward flush, which the lower caches see as an ordinary bus read. The data returned by the flush is passed up, and the line stays present but is no longer exclusive. When a victim line is evicted, its address is invalidated below first, so that inclusion holds.

Upper-bus snoops wait in a small queue and are handled one at a time, in the order they arrived. A lower-bus request that cannot be served in the current cycle is answered with a retry.

Top module: `l2_coh_bridge`

## Requirements
- R1: After reset every line is Invalid, and all of dn_valid, up_valid, lo_ack, lo_retry and us_rsp_valid are 0.
- R2: A lower read (lo_req_wr=0) that hits a line in any non-Invalid state raises lo_ack in the next cycle. It causes no upper or downward traffic.
- R3: A lower request that misses on an empty line index raises up_valid in the next cycle, with the request's address and op (1 = write, 0 = read). The cycle after up_ack is seen, up_valid drops and lo_ack is 1. A read installs the line as Valid.
- R4: A lower write to a line that is Valid here, or that misses, is sent up as a write, and the line becomes Reserved once the upper bus acknowledges it.
- R5: A lower write to a line that is Reserved or Dirty here is acknowledged in the next cycle, with no upper traffic, and the line becomes Dirty.
- R6: A lower miss on an index that holds a different valid tag first drives dn_valid for one cycle, with dn_wr=1 and the victim's address, and drops the victim. up_valid for the new address rises in the next cycle.
- R7: An upper write snoop (us_wr=1) that matches a held line invalidates it here and drives one cycle of dn_valid with dn_wr=1 and that address.
- R8: An upper read snoop that matches a Dirty line drives dn_valid with dn_wr=0 (a flush). It then waits for dn_resp_valid. In the cycle after that, us_rsp_valid is 1, with us_rsp_dirty and us_rsp_data copied from below, and the line becomes Valid.
- R9: An upper read snoop on a Reserved line makes the line Valid with no downward traffic. Read snoops on Valid or absent lines, and write snoops on absent lines, cause no downward traffic and no change of state.
- R10: Queued upper snoops are handled one per idle cycle, in arrival order. A non-empty queue takes priority over a lower request.
- R11: A lower request that arrives while the bridge is busy, or while snoops are queued, gets lo_retry in the next cycle and changes no state.
- R12: Once up_valid is raised, it stays high with the same address and op until up_ack is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lo_req_valid | input | 1 | Lower-bus request present |
| lo_req_wr | input | 1 | Lower request op: 1 write, 0 read |
| lo_req_addr | input | ADDR_W | Lower request line address |
| lo_ack | output | 1 | Lower request completed (one cycle) |
| lo_retry | output | 1 | Lower request must be re-issued (one cycle) |
| dn_valid | output | 1 | Downward request on lower bus (one cycle) |
| dn_wr | output | 1 | 1 invalidate (seen as write), 0 flush (seen as read) |
| dn_addr | output | ADDR_W | Downward request address |
| dn_resp_valid | input | 1 | Lower bus answers a flush |
| dn_resp_dirty | input | 1 | A modified copy was returned |
| dn_resp_data | input | DATA_W | Returned data |
| up_valid | output | 1 | Upper-bus request pending |
| up_wr | output | 1 | Upper request op: 1 write, 0 read |
| up_addr | output | ADDR_W | Upper request address |
| up_ack | input | 1 | Upper bus completes the pending request |
| us_valid | input | 1 | Upper-bus snoop event |
| us_wr | input | 1 | Snooped op: 1 write, 0 read |
| us_addr | input | ADDR_W | Snooped address |
| us_rsp_valid | output | 1 | Flush result forwarded upward (one cycle) |
| us_rsp_dirty | output | 1 | Forwarded data is modified |
| us_rsp_data | output | DATA_W | Forwarded data |

## Verification
The bench goes after the Dirty-versus-Reserved split on remote reads. A bridge that flushes a Reserved line sends needless traffic down, and one that skips the flush on a Dirty line loses modified data. It sends a miss into an occupied index, so that a missing or late victim invalidate shows up as an up_valid with no dn_valid in the cycle before it. It queues several snoops during a long upper wait and holds a lower request alongside them. A design that reorders snoops, lets a lower request overtake the queue, or lets up_valid drop early differs from the per-cycle model. A line whose state is demoted wrongly is exposed by the next lower write, which must or must not travel upward.

// File: rtl/l2cb_pkg.sv
package l2cb_pkg;
    typedef enum logic [1:0] {
        LS_INV = 2'd0,
        LS_VAL = 2'd1,
        LS_RES = 2'd2,
        LS_DRT = 2'd3
    } lstate_e;

    typedef enum logic [1:0] {
        F_IDLE   = 2'd0,
        F_EVICT  = 2'd1,
        F_UPWAIT = 2'd2,
        F_FLUSH  = 2'd3
    } fsm_e;
endpackage

// File: rtl/l2cb_tag_array.sv
module l2cb_tag_array
    import l2cb_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int INDEX_W = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [INDEX_W-1:0]          ra_idx,
    output lstate_e                     ra_st,
    output logic [ADDR_W-INDEX_W-1:0]   ra_tag,
    input  logic [INDEX_W-1:0]          rb_idx,
    output lstate_e                     rb_st,
    output logic [ADDR_W-INDEX_W-1:0]   rb_tag,
    input  logic                        we,
    input  logic [INDEX_W-1:0]          w_idx,
    input  lstate_e                     w_st,
    input  logic [ADDR_W-INDEX_W-1:0]   w_tag
);
    localparam int LINES = 1 << INDEX_W;
    localparam int TAG_W = ADDR_W - INDEX_W;

    lstate_e            st_q  [LINES];
    logic [TAG_W-1:0]   tag_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        lstate_e          st_d;
        logic [TAG_W-1:0] tag_d;
        always_comb begin
            st_d  = st_q[g];
            tag_d = tag_q[g];
            if (we && (w_idx == INDEX_W'(g))) begin
                st_d  = w_st;
                tag_d = w_tag;
            end
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g]  <= LS_INV;
                tag_q[g] <= '0;
            end else begin
                st_q[g]  <= st_d;
                tag_q[g] <= tag_d;
            end
        end
    end

    assign ra_st  = st_q[ra_idx];
    assign ra_tag = tag_q[ra_idx];
    assign rb_st  = st_q[rb_idx];
    assign rb_tag = tag_q[rb_idx];

    // R1: the first cycle after reset sees every line empty
    a_r1_reset_empty: assert property (@(posedge clk)
        $fell(rst_n) |=> (st_q[0] == LS_INV));
endmodule

// File: rtl/l2cb_snoop_fifo.sv
module l2cb_snoop_fifo #(
    parameter int W     = 17,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t         p_d, p_q;
    logic [W-1:0] mem_q [DEPTH];
    logic         full;
    logic         do_push;

    assign full    = (p_q.cnt == CW'(DEPTH));
    assign empty   = (p_q.cnt == '0);
    assign do_push = push && (!full || pop);
    assign head    = mem_q[p_q.rd];

    always_comb begin
        p_d = p_q;
        if (do_push) p_d.wr = (p_q.wr == LAST) ? '0 : p_q.wr + 1'b1;
        if (pop)     p_d.rd = (p_q.rd == LAST) ? '0 : p_q.rd + 1'b1;
        p_d.cnt = p_q.cnt + CW'(do_push) - CW'(pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[p_q.wr] <= push_data;
    end

    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (!full || pop));
    a_r10_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/l2_coh_bridge.sv
module l2_coh_bridge
    import l2cb_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int INDEX_W   = 4,
    parameter int DATA_W    = 32,
    parameter int SNQ_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_req_valid,
    input  logic              lo_req_wr,
    input  logic [ADDR_W-1:0] lo_req_addr,
    output logic              lo_ack,
    output logic              lo_retry,
    output logic              dn_valid,
    output logic              dn_wr,
    output logic [ADDR_W-1:0] dn_addr,
    input  logic              dn_resp_valid,
    input  logic              dn_resp_dirty,
    input  logic [DATA_W-1:0] dn_resp_data,
    output logic              up_valid,
    output logic              up_wr,
    output logic [ADDR_W-1:0] up_addr,
    input  logic              up_ack,
    input  logic              us_valid,
    input  logic              us_wr,
    input  logic [ADDR_W-1:0] us_addr,
    output logic              us_rsp_valid,
    output logic              us_rsp_dirty,
    output logic [DATA_W-1:0] us_rsp_data
);
    localparam int TAG_W = ADDR_W - INDEX_W;
    localparam int SN_W  = ADDR_W + 1;

    typedef struct packed {
        fsm_e              fsm;
        logic [ADDR_W-1:0] addr;
        logic              wr;
        logic              dn_v;
        logic              dn_wr;
        logic [ADDR_W-1:0] dn_a;
        logic              up_v;
        logic              up_wr;
        logic [ADDR_W-1:0] up_a;
        logic              ack;
        logic              retry;
        logic              rsp_v;
        logic              rsp_d;
        logic [DATA_W-1:0] rsp_data;
    } ctl_t;

    ctl_t r_d, r_q;

    // snoop queue
    logic            q_empty, pop;
    logic [SN_W-1:0] sn_head;
    logic            sn_wr;
    logic [ADDR_W-1:0] sn_addr;

    l2cb_snoop_fifo #(.W(SN_W), .DEPTH(SNQ_DEPTH)) u_snq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (us_valid),
        .push_data ({us_wr, us_addr}),
        .pop       (pop),
        .head      (sn_head),
        .empty     (q_empty)
    );

    assign sn_wr   = sn_head[SN_W-1];
    assign sn_addr = sn_head[ADDR_W-1:0];

    // tag and state array
    logic [INDEX_W-1:0] lo_idx, sn_idx, q_idx, w_idx;
    logic [TAG_W-1:0]   lo_tag, sn_tag, q_tag, w_tag;
    lstate_e            lo_st, sn_st, w_st;
    logic [TAG_W-1:0]   lo_line_tag, sn_line_tag;
    logic               we;

    assign lo_idx = lo_req_addr[INDEX_W-1:0];
    assign lo_tag = lo_req_addr[ADDR_W-1:INDEX_W];
    assign sn_idx = sn_addr[INDEX_W-1:0];
    assign sn_tag = sn_addr[ADDR_W-1:INDEX_W];
    assign q_idx  = r_q.addr[INDEX_W-1:0];
    assign q_tag  = r_q.addr[ADDR_W-1:INDEX_W];

    l2cb_tag_array #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) u_tags (
        .clk    (clk),
        .rst_n  (rst_n),
        .ra_idx (lo_idx),
        .ra_st  (lo_st),
        .ra_tag (lo_line_tag),
        .rb_idx (sn_idx),
        .rb_st  (sn_st),
        .rb_tag (sn_line_tag),
        .we     (we),
        .w_idx  (w_idx),
        .w_st   (w_st),
        .w_tag  (w_tag)
    );

    logic lo_hit, lo_excl, sn_hit;
    assign lo_hit  = (lo_st != LS_INV) && (lo_line_tag == lo_tag);
    assign lo_excl = (lo_st == LS_RES) || (lo_st == LS_DRT);
    assign sn_hit  = (sn_st != LS_INV) && (sn_line_tag == sn_tag);

    always_comb begin
        r_d       = r_q;
        r_d.dn_v  = 1'b0;
        r_d.ack   = 1'b0;
        r_d.retry = 1'b0;
        r_d.rsp_v = 1'b0;
        we        = 1'b0;
        w_idx     = lo_idx;
        w_tag     = lo_tag;
        w_st      = LS_INV;
        pop       = 1'b0;
        case (r_q.fsm)
            F_IDLE: begin
                if (!q_empty) begin
                    pop = 1'b1;
                    if (lo_req_valid) r_d.retry = 1'b1;
                    if (sn_hit && sn_wr) begin
                        we        = 1'b1;
                        w_idx     = sn_idx;
                        w_tag     = sn_tag;
                        w_st      = LS_INV;
                        r_d.dn_v  = 1'b1;
                        r_d.dn_wr = 1'b1;
                        r_d.dn_a  = sn_addr;
                    end else if (sn_hit && (sn_st == LS_DRT)) begin
                        r_d.dn_v  = 1'b1;
                        r_d.dn_wr = 1'b0;
                        r_d.dn_a  = sn_addr;
                        r_d.addr  = sn_addr;
                        r_d.fsm   = F_FLUSH;
                    end else if (sn_hit && (sn_st == LS_RES)) begin
                        we    = 1'b1;
                        w_idx = sn_idx;
                        w_tag = sn_tag;
                        w_st  = LS_VAL;
                    end
                end else if (lo_req_valid) begin
                    r_d.addr = lo_req_addr;
                    r_d.wr   = lo_req_wr;
                    if (lo_hit && !lo_req_wr) begin
                        r_d.ack = 1'b1;
                    end else if (lo_hit && lo_excl) begin
                        we      = 1'b1;
                        w_st    = LS_DRT;
                        r_d.ack = 1'b1;
                    end else if (lo_hit) begin
                        r_d.up_v  = 1'b1;
                        r_d.up_wr = 1'b1;
                        r_d.up_a  = lo_req_addr;
                        r_d.fsm   = F_UPWAIT;
                    end else if (lo_st != LS_INV) begin
                        we        = 1'b1;
                        w_tag     = lo_line_tag;
                        w_st      = LS_INV;
                        r_d.dn_v  = 1'b1;
                        r_d.dn_wr = 1'b1;
                        r_d.dn_a  = {lo_line_tag, lo_idx};
                        r_d.fsm   = F_EVICT;
                    end else begin
                        r_d.up_v  = 1'b1;
                        r_d.up_wr = lo_req_wr;
                        r_d.up_a  = lo_req_addr;
                        r_d.fsm   = F_UPWAIT;
                    end
                end
            end
            F_EVICT: begin
                if (lo_req_valid) r_d.retry = 1'b1;
                r_d.up_v  = 1'b1;
                r_d.up_wr = r_q.wr;
                r_d.up_a  = r_q.addr;
                r_d.fsm   = F_UPWAIT;
            end
            F_UPWAIT: begin
                if (lo_req_valid) r_d.retry = 1'b1;
                if (up_ack) begin
                    r_d.up_v = 1'b0;
                    we       = 1'b1;
                    w_idx    = q_idx;
                    w_tag    = q_tag;
                    w_st     = r_q.wr ? LS_RES : LS_VAL;
                    r_d.ack  = 1'b1;
                    r_d.fsm  = F_IDLE;
                end
            end
            F_FLUSH: begin
                if (lo_req_valid) r_d.retry = 1'b1;
                if (dn_resp_valid) begin
                    r_d.rsp_v    = 1'b1;
                    r_d.rsp_d    = dn_resp_dirty;
                    r_d.rsp_data = dn_resp_data;
                    we           = 1'b1;
                    w_idx        = q_idx;
                    w_tag        = q_tag;
                    w_st         = LS_VAL;
                    r_d.fsm      = F_IDLE;
                end
            end
            default: r_d.fsm = F_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign lo_ack       = r_q.ack;
    assign lo_retry     = r_q.retry;
    assign dn_valid     = r_q.dn_v;
    assign dn_wr        = r_q.dn_wr;
    assign dn_addr      = r_q.dn_a;
    assign up_valid     = r_q.up_v;
    assign up_wr        = r_q.up_wr;
    assign up_addr      = r_q.up_a;
    assign us_rsp_valid = r_q.rsp_v;
    assign us_rsp_dirty = r_q.rsp_d;
    assign us_rsp_data  = r_q.rsp_data;

    a_r12_up_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && !up_ack) |=> (up_valid && $stable(up_addr) && $stable(up_wr)));
    a_r3_ack_after_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (up_valid && up_ack) |=> (lo_ack && !up_valid));
    a_r11_busy_retry: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_req_valid && (r_q.fsm != F_IDLE)) |=> lo_retry);
    a_r8_flush_answer: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.fsm == F_FLUSH) && dn_resp_valid) |=>
            (us_rsp_valid && (us_rsp_dirty == $past(dn_resp_dirty))));
    a_r6_evict_then_up: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.fsm == F_EVICT) |=> (up_valid && (up_addr == $past(r_q.addr))));
endmodule

// File: tb/l2_coh_bridge_test.sv
module l2_coh_bridge_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic        lo_req_valid = 0, lo_req_wr = 0;
    logic [15:0] lo_req_addr = 0;
    logic        lo_ack, lo_retry, dn_valid, dn_wr;
    logic [15:0] dn_addr;
    logic        dn_resp_valid = 0, dn_resp_dirty = 0;
    logic [31:0] dn_resp_data = 0;
    logic        up_valid, up_wr, up_ack = 0;
    logic [15:0] up_addr;
    logic        us_valid = 0, us_wr = 0;
    logic [15:0] us_addr = 0;
    logic        us_rsp_valid, us_rsp_dirty;
    logic [31:0] us_rsp_data;

    l2_coh_bridge uut (
        .clk(clk), .rst_n(rst_n),
        .lo_req_valid(lo_req_valid), .lo_req_wr(lo_req_wr), .lo_req_addr(lo_req_addr),
        .lo_ack(lo_ack), .lo_retry(lo_retry),
        .dn_valid(dn_valid), .dn_wr(dn_wr), .dn_addr(dn_addr),
        .dn_resp_valid(dn_resp_valid), .dn_resp_dirty(dn_resp_dirty), .dn_resp_data(dn_resp_data),
        .up_valid(up_valid), .up_wr(up_wr), .up_addr(up_addr), .up_ack(up_ack),
        .us_valid(us_valid), .us_wr(us_wr), .us_addr(us_addr),
        .us_rsp_valid(us_rsp_valid), .us_rsp_dirty(us_rsp_dirty), .us_rsp_data(us_rsp_data)
    );

    int    errors = 0, checks = 0, cyc = 0;
    string cur_req = "R1";
    bit    done = 0;

    task automatic cmp(string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", cur_req, what, act, exp);
        end
    endtask

    // behavioural reference: line states 0 I, 1 V, 2 R, 3 D; phase 0 idle, 1 evict, 2 wait up, 3 flush
    int          mst [16];
    logic [11:0] mtag [16];
    logic [16:0] sq [$];
    int          mf = 0;
    logic [15:0] ma = 0;
    logic        mwr = 0;
    logic        e_dn_v = 0, e_dn_wr = 0, e_up_v = 0, e_up_wr = 0;
    logic        e_ack = 0, e_retry = 0, e_rsp_v = 0, e_rsp_d = 0;
    logic [15:0] e_dn_a = 0, e_up_a = 0;
    logic [31:0] e_rsp_data = 0;
    logic [16:0] s;
    int          li;
    bit          hit;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 16; k++) begin mst[k] = 0; mtag[k] = 0; end
            sq.delete();
            mf = 0; e_dn_v = 0; e_up_v = 0; e_ack = 0; e_retry = 0; e_rsp_v = 0;
        end else begin
            e_dn_v = 0; e_ack = 0; e_retry = 0; e_rsp_v = 0;
            if (mf == 0) begin
                if (sq.size() != 0) begin
                    s = sq.pop_front();
                    li = int'(s[3:0]);
                    hit = (mst[li] != 0) && (mtag[li] == s[15:4]);
                    if (lo_req_valid) e_retry = 1;
                    if (hit && s[16]) begin
                        mst[li] = 0; e_dn_v = 1; e_dn_wr = 1; e_dn_a = s[15:0];
                    end else if (hit && mst[li] == 3) begin
                        e_dn_v = 1; e_dn_wr = 0; e_dn_a = s[15:0]; ma = s[15:0]; mf = 3;
                    end else if (hit && mst[li] == 2) begin
                        mst[li] = 1;
                    end
                end else if (lo_req_valid) begin
                    li = int'(lo_req_addr[3:0]);
                    hit = (mst[li] != 0) && (mtag[li] == lo_req_addr[15:4]);
                    ma = lo_req_addr; mwr = lo_req_wr;
                    if (hit && !lo_req_wr) e_ack = 1;
                    else if (hit && mst[li] >= 2) begin mst[li] = 3; e_ack = 1; end
                    else if (hit) begin e_up_v = 1; e_up_wr = 1; e_up_a = ma; mf = 2; end
                    else if (mst[li] != 0) begin
                        e_dn_v = 1; e_dn_wr = 1; e_dn_a = {mtag[li], lo_req_addr[3:0]};
                        mst[li] = 0; mf = 1;
                    end else begin e_up_v = 1; e_up_wr = mwr; e_up_a = ma; mf = 2; end
                end
            end else begin
                if (lo_req_valid) e_retry = 1;
                if (mf == 1) begin
                    e_up_v = 1; e_up_wr = mwr; e_up_a = ma; mf = 2;
                end else if (mf == 2) begin
                    if (up_ack) begin
                        e_up_v = 0; li = int'(ma[3:0]);
                        mst[li] = mwr ? 2 : 1; mtag[li] = ma[15:4]; e_ack = 1; mf = 0;
                    end
                end else if (dn_resp_valid) begin
                    e_rsp_v = 1; e_rsp_d = dn_resp_dirty; e_rsp_data = dn_resp_data;
                    mst[int'(ma[3:0])] = 1; mf = 0;
                end
            end
            if (us_valid) sq.push_back({us_wr, us_addr});
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            cmp("dn_valid", 32'(dn_valid), 32'(e_dn_v));
            if (e_dn_v) begin
                cmp("dn_wr", 32'(dn_wr), 32'(e_dn_wr));
                cmp("dn_addr", 32'(dn_addr), 32'(e_dn_a));
            end
            cmp("up_valid", 32'(up_valid), 32'(e_up_v));
            if (e_up_v) begin
                cmp("up_wr", 32'(up_wr), 32'(e_up_wr));
                cmp("up_addr", 32'(up_addr), 32'(e_up_a));
            end
            cmp("lo_ack", 32'(lo_ack), 32'(e_ack));
            cmp("lo_retry", 32'(lo_retry), 32'(e_retry));
            cmp("us_rsp_valid", 32'(us_rsp_valid), 32'(e_rsp_v));
            if (e_rsp_v) begin
                cmp("us_rsp_dirty", 32'(us_rsp_dirty), 32'(e_rsp_d));
                cmp("us_rsp_data", us_rsp_data, e_rsp_data);
            end
        end
    end

    // upper bus model
    int up_cnt = 0, up_lat = 2;
    always @(negedge clk) begin
        if (up_ack) up_ack = 0;
        else if (up_valid) begin
            up_cnt++;
            if (up_cnt >= up_lat) begin up_ack = 1; up_cnt = 0; end
        end
    end

    // lower caches model: answer a flush three cycles later
    int          fl_cnt = 0;
    logic        fl_dirty = 0;
    logic [31:0] fl_data = 0;
    always @(negedge clk) begin
        dn_resp_valid = 0;
        if (fl_cnt > 0) begin
            fl_cnt--;
            if (fl_cnt == 0) begin
                dn_resp_valid = 1; dn_resp_dirty = fl_dirty; dn_resp_data = fl_data;
            end
        end
        if (dn_valid && !dn_wr) fl_cnt = 3;
    end

    task automatic lo_op(logic [15:0] a, logic w);
        @(negedge clk);
        lo_req_valid = 1; lo_req_addr = a; lo_req_wr = w;
        @(negedge clk);
        lo_req_valid = 0;
        repeat (12) @(negedge clk);
    endtask

    task automatic snoop(logic [15:0] a, logic w);
        @(negedge clk);
        us_valid = 1; us_addr = a; us_wr = w;
        @(negedge clk);
        us_valid = 0;
        repeat (10) @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            errors++;
            done = 1;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (2) @(negedge clk);
        cur_req = "R3"; lo_op(16'h0013, 0);          // read miss, fetch
        cur_req = "R2"; lo_op(16'h0013, 0);          // read hit
        cur_req = "R4"; lo_op(16'h0013, 1);          // write on Valid goes up
        cur_req = "R5"; lo_op(16'h0013, 1);          // write on Reserved stays local
        cur_req = "R8";
        fl_dirty = 1; fl_data = 32'hCAFE0013;
        @(negedge clk); us_valid = 1; us_addr = 16'h0013; us_wr = 0;
        @(negedge clk); us_valid = 0;
        lo_req_valid = 1; lo_req_addr = 16'h0013; lo_req_wr = 0;
        @(negedge clk); cur_req = "R11";
        @(negedge clk); lo_req_valid = 0;
        repeat (10) @(negedge clk);
        cur_req = "R4"; lo_op(16'h0013, 1);          // line now Valid: goes up
        cur_req = "R9"; snoop(16'h0013, 0);          // Reserved -> Valid, no flush
        lo_op(16'h0013, 1);                          // proves Valid: goes up again
        cur_req = "R6"; lo_op(16'h0023, 0);          // evicts 0x0013
        cur_req = "R7"; snoop(16'h0023, 1);          // invalidate down
        lo_op(16'h0023, 0);
        cur_req = "R9"; snoop(16'h0055, 1);
        snoop(16'h0023, 0);
        snoop(16'h0013, 1);
        cur_req = "R10"; up_lat = 6;
        @(negedge clk); lo_req_valid = 1; lo_req_addr = 16'h0044; lo_req_wr = 0;
        @(negedge clk); lo_req_valid = 0; us_valid = 1; us_addr = 16'h0099; us_wr = 0;
        @(negedge clk); us_addr = 16'h0023; us_wr = 1;
        @(negedge clk); us_addr = 16'h0013; us_wr = 0;
        @(negedge clk); us_valid = 0; cur_req = "R12";
        lo_req_valid = 1; lo_req_addr = 16'h0077; lo_req_wr = 0;
        repeat (8) @(negedge clk);
        lo_req_valid = 0;
        repeat (20) @(negedge clk);
        up_lat = 2;
        cur_req = "R8"; fl_dirty = 0; fl_data = 32'h0;
        lo_op(16'h0077, 1);                          // Valid -> Reserved via upper write
        lo_op(16'h0077, 1);                          // Reserved -> Dirty
        snoop(16'h0077, 0);                          // flush returns clean answer
        repeat (4) @(negedge clk);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule